// File: doc/BRIEF.md
# Doorbell Mailbox Controller

A twelve-channel mailbox that sits between a host processor and an embedded controller. Both sides share one data RAM. A 32-bit host register bus reaches that RAM and four control registers. To send, the host writes a payload into the transmit part of the RAM and rings the channel's doorbell. This raises a per-channel pending flag toward the remote side. The remote side reads the payload through its own read port and pulses a per-channel consume input, which lowers the flag.

Replies travel the other way. The remote side writes its payload into the receive part of the RAM and pulses a per-channel post input. This sets a receive status bit. Any set receive bit drives the single host interrupt line. The host reads the reply and acknowledges it by writing that channel's bit to the interrupt clear register.

The host bus uses byte addresses. The data RAM starts at 0x000 and holds 96 words, 0x000 to 0x17F. The transmit windows of all channels lie in words 0 to 55 (0x000 to 0x0DF). The receive windows lie in words 56 to 91 (0x0E0 to 0x16F). Software places each channel's window inside these regions. The control registers sit at 0x200 plus an offset.

Top module: `dbell_mbox`

## Requirements
- R1: While rst_n is low, all transmit and receive status bits, the whole data RAM and host_irq are cleared, so the first reads after reset return zero.
- R2: A host write to a byte address below 0x0E0 stores the word at index addr[9:2]. A host read of a RAM word returns it on bus_rdata, with bus_rvalid high, in the cycle after the request. Addresses 0x180 to 0x1FF read zero.
- R3: Host writes at or above 0x0E0 in the data area are ignored. Remote writes are stored only to word indices 56 to 91 and are ignored elsewhere.
- R4: Writing to the doorbell register at 0x204 sets the transmit status bits under the ones in bus_wdata[11:0]. Zero bits leave their channel unchanged. The register reads as zero.
- R5: The transmit status register at 0x200 holds a 1 per channel until a rmt_consume pulse on that channel clears it. A consume in the same cycle as a doorbell set on the same bit wins, and the bit ends at 0.
- R6: A rmt_post pulse sets that channel's bit in the receive status register at 0x278. Writing ones to the clear register at 0x274 clears the matching bits. Zero bits have no effect, and 0x274 reads as zero. A post in the same cycle as a clear on the same bit wins, and the bit ends at 1.
- R7: host_irq is high exactly while any receive status bit is set. It falls in the cycle after the clear of the last set bit.
- R8: tx_pending mirrors the transmit status bits. rmt_rdata returns the RAM word at rmt_raddr in the same cycle, or zero if the index is 96 or above.
- R9: In every status and control register, bit n belongs to channel n, for channels 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host bus access request |
| bus_we | input | 1 | Host write (1) or read (0) |
| bus_addr | input | 10 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_irq | output | 1 | Shared receive interrupt to the host |
| tx_pending | output | 12 | Per-channel transmit pending flags to the remote side |
| rmt_consume | input | 12 | Per-channel pulses: remote consumed the message |
| rmt_post | input | 12 | Per-channel pulses: remote posted a reply |
| rmt_we | input | 1 | Remote RAM write enable |
| rmt_waddr | input | 7 | Remote RAM write word index |
| rmt_wdata | input | 32 | Remote RAM write data |
| rmt_raddr | input | 7 | Remote RAM read word index |
| rmt_rdata | output | 32 | Remote RAM read data |

## Verification
The bench targets collisions in a single cycle. A consume that meets a doorbell on the same bit must leave the bit clear. A post that meets a clear on the same bit must leave it set. A design with the priority reversed would lose a reply or report a message that was never consumed. The bench also writes zero masks and reads back the action registers; a design that treated them as plain registers would change status or return stale data. It probes the boundary between the two RAM regions from both sides, where a wrong limit would let one side overwrite the other's payload. Finally it checks that the interrupt falls only when the last of several pending bits is cleared.

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
  parameter int NCH        = 12,
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int DATA_WORDS = 96,
  parameter int TX_WORDS   = 56,
  parameter int RX_WORDS   = 36,
  parameter logic [AW-1:0] CTRL_BASE = 10'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic              host_irq,
  output logic [NCH-1:0]    tx_pending,
  input  logic [NCH-1:0]    rmt_consume,
  input  logic [NCH-1:0]    rmt_post,
  input  logic              rmt_we,
  input  logic [$clog2(DATA_WORDS)-1:0] rmt_waddr,
  input  logic [DW-1:0]     rmt_wdata,
  input  logic [$clog2(DATA_WORDS)-1:0] rmt_raddr,
  output logic [DW-1:0]     rmt_rdata
);
  localparam int WA = $clog2(DATA_WORDS);
  localparam int RX_END = TX_WORDS + RX_WORDS;
  localparam logic [AW-3:0] HOST_DLIM = DATA_WORDS[AW-3:0];
  localparam logic [AW-3:0] HOST_TLIM = TX_WORDS[AW-3:0];
  localparam logic [WA-1:0] RMT_LO    = TX_WORDS[WA-1:0];
  localparam logic [WA-1:0] RMT_HI    = RX_END[WA-1:0];
  localparam logic [WA-1:0] RMT_DLIM  = DATA_WORDS[WA-1:0];
  localparam logic [7:0] OFS_TXS = 8'h00;
  localparam logic [7:0] OFS_DB  = 8'h04;
  localparam logic [7:0] OFS_CLR = 8'h74;
  localparam logic [7:0] OFS_RXS = 8'h78;

  logic [DW-1:0]  mem [DATA_WORDS];
  logic [NCH-1:0] tx_sts, rx_sts;

  wire [AW-3:0] widx    = bus_addr[AW-1:2];
  wire [7:0]    ofs     = bus_addr[7:0];
  wire          is_ctrl = bus_addr[AW-1:8] == CTRL_BASE[AW-1:8];
  wire          is_data = !is_ctrl && (widx < HOST_DLIM);
  wire          hwr     = bus_req && bus_we;
  wire          hrd     = bus_req && !bus_we;
  wire          db_hit  = hwr && is_ctrl && (ofs == OFS_DB);
  wire          clr_hit = hwr && is_ctrl && (ofs == OFS_CLR);
  wire          ram_hwr = hwr && !is_ctrl && (widx < HOST_TLIM);
  wire          ram_rwr = rmt_we && (rmt_waddr >= RMT_LO) && (rmt_waddr < RMT_HI);
  wire [NCH-1:0] set_v  = db_hit  ? bus_wdata[NCH-1:0] : '0;
  wire [NCH-1:0] clr_v  = clr_hit ? bus_wdata[NCH-1:0] : '0;

  assign host_irq   = |rx_sts;
  assign tx_pending = tx_sts;
  assign rmt_rdata  = (rmt_raddr < RMT_DLIM) ? mem[rmt_raddr] : '0;

  // remote events are applied last so they win a same-cycle collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sts <= '0;
      rx_sts <= '0;
    end else begin
      tx_sts <= (tx_sts | set_v) & ~rmt_consume;
      rx_sts <= (rx_sts & ~clr_v) | rmt_post;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_WORDS; i++) mem[i] <= '0;
    end else begin
      if (ram_hwr) mem[widx[WA-1:0]] <= bus_wdata;
      if (ram_rwr) mem[rmt_waddr] <= rmt_wdata;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (is_ctrl) begin
      if (ofs == OFS_TXS) rd_mux = {{(DW-NCH){1'b0}}, tx_sts};
      else if (ofs == OFS_RXS) rd_mux = {{(DW-NCH){1'b0}}, rx_sts};
    end else if (is_data) begin
      rd_mux = mem[widx[WA-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= hrd;
      if (hrd) bus_rdata <= rd_mux;
    end
  end

  wire rd_zero = hrd && is_ctrl && (ofs == OFS_DB || ofs == OFS_CLR);

  assert_txrise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_sts & ~$past(tx_sts)) != '0) |-> $past(db_hit));
  assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rmt_consume) |=> ((tx_sts & $past(rmt_consume)) == '0));
  assert_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rmt_post) |=> ((rx_sts & $past(rmt_post)) == $past(rmt_post)));
  assert_irqrise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|rmt_post));
  assert_actzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_zero) |-> (bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/dbell_mbox_bench.sv
module dbell_mbox_bench;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rmt_rdata;
  logic bus_rvalid, host_irq;
  logic [11:0] tx_pending, rmt_consume = '0, rmt_post = '0;
  logic rmt_we = 0;
  logic [6:0] rmt_waddr = '0, rmt_raddr = '0;
  logic [31:0] rmt_wdata = '0;
  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbell_mbox u_dbell_mbox (.clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_rvalid, .host_irq, .tx_pending, .rmt_consume, .rmt_post,
    .rmt_we, .rmt_waddr, .rmt_wdata, .rmt_raddr, .rmt_rdata);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0; d = bus_rdata;
    chk("R2 rvalid", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic rpulse(input logic [11:0] cons, input logic [11:0] post);
    @(negedge clk); rmt_consume = cons; rmt_post = post;
    @(negedge clk); rmt_consume = '0; rmt_post = '0;
  endtask

  task automatic rwr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); rmt_we = 1; rmt_waddr = a; rmt_wdata = d;
    @(negedge clk); rmt_we = 0;
  endtask

  // {read(1)/write(0), requirement number, address, data or expected}
  localparam int NV = 11;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 4'd2, 10'h000, 32'h11111111},
    {1'b0, 4'd2, 10'h0DC, 32'hDCDC0001},
    {1'b0, 4'd3, 10'h0E0, 32'h0000BAD0},
    {1'b0, 4'd4, 10'h204, 32'h00000005},
    {1'b1, 4'd2, 10'h000, 32'h11111111},
    {1'b1, 4'd2, 10'h0DC, 32'hDCDC0001},
    {1'b1, 4'd3, 10'h0E0, 32'h00000000},
    {1'b1, 4'd9, 10'h200, 32'h00000005},
    {1'b1, 4'd4, 10'h204, 32'h00000000},
    {1'b1, 4'd6, 10'h278, 32'h00000000},
    {1'b1, 4'd2, 10'h180, 32'h00000000}
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'd0, host_irq}, 0);
    chk("R1 tx_pending", {20'd0, tx_pending}, 0);
    brd(10'h200, r); chk("R1 txsts", r, 0);
    brd(10'h000, r); chk("R1 ram", r, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46]) begin
        brd(VEC[i][41:32], r);
        chk($sformatf("R%0d vec%0d", VEC[i][45:42], i), r, VEC[i][31:0]);
      end else begin
        bwr(VEC[i][41:32], VEC[i][31:0]);
      end
    end

    // R8 tx_pending mirror, R5 consume clears ch2 only
    chk("R8 pending", {20'd0, tx_pending}, 32'h5);
    rpulse(12'h004, 12'h000);
    brd(10'h200, r); chk("R5 consume", r, 32'h1);
    bwr(10'h204, 32'h0); brd(10'h200, r); chk("R4 zero write", r, 32'h1);
    // R5 collision: consume beats doorbell on ch5
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = 10'h204; bus_wdata = 32'h20;
    rmt_consume = 12'h020;
    @(negedge clk); bus_req = 0; bus_we = 0; rmt_consume = '0;
    brd(10'h200, r); chk("R5 collision", r, 32'h1);

    // R3 remote write region limits, R8 remote read
    rwr(7'd56, 32'hCAFE0001); rwr(7'd10, 32'hBAD); rwr(7'd92, 32'hBAD);
    brd(10'h0E0, r); chk("R3 rmt in rx", r, 32'hCAFE0001);
    brd(10'h028, r); chk("R3 rmt in tx", r, 0);
    rmt_raddr = 7'd92; #1 chk("R3 rmt past rx", rmt_rdata, 0);
    rmt_raddr = 7'd0;  #1 chk("R8 rmt read", rmt_rdata, 32'h11111111);
    rmt_raddr = 7'd100; #1 chk("R8 rmt oob", rmt_rdata, 0);

    // R6/R7/R9 receive path
    rpulse(12'h000, 12'h808);
    chk("R7 irq up", {31'd0, host_irq}, 1);
    brd(10'h278, r); chk("R9 rxsts", r, 32'h808);
    bwr(10'h274, 32'h0); brd(10'h278, r); chk("R6 zero clear", r, 32'h808);
    brd(10'h274, r); chk("R6 clr reads 0", r, 0);
    bwr(10'h274, 32'h800); chk("R7 irq held", {31'd0, host_irq}, 1);
    bwr(10'h274, 32'h008); chk("R7 irq drop", {31'd0, host_irq}, 0);
    // R6 collision: post beats clear on ch6
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = 10'h274; bus_wdata = 32'h40;
    rmt_post = 12'h040;
    @(negedge clk); bus_req = 0; bus_we = 0; rmt_post = '0;
    brd(10'h278, r); chk("R6 collision", r, 32'h40);
    chk("R7 irq collision", {31'd0, host_irq}, 1);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    chk("R1 irq after", {31'd0, host_irq}, 0);
    brd(10'h000, r); chk("R1 ram after", r, 0);
    brd(10'h0E0, r); chk("R1 rx ram after", r, 0);
    brd(10'h200, r); chk("R1 tx after", r, 0);
    brd(10'h278, r); chk("R1 rx after", r, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule